// File: doc/BRIEF.md
# Firmware-Update Entry Waveform Generator

This block takes over the two wires of an I2C bus for a short while and drives a fixed timing pattern on them. The pattern tells an attached target to enter its direct firmware-update mode. The sequence is started by a one-cycle request, but only when a permit input is high. During the sequence the block owns the pins. When the sequence ends, a mux select hands the pins back to the normal I2C controller.

The sequence has three phases, all timed from a 1 µs tick that is prescaled from the system clock:

- **Hold:** both lines are driven low for 5 ms.
- **Pattern:** lasts 50 ms. SCL is a 100 kHz square wave. SDA toggles at twice that rate and is inverted, so that each SDA rising edge falls inside an SCL half-period rather than on an SCL edge.
- **Settle:** both lines are driven low for 10 ms so that the target's clock can settle.

All durations are parameters, so the same block can be shortened for simulation.

Top module: `dfu_entry_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `denied_o`, `mux_sel_o`, `scl_o` and `sda_o` are all 0, and both lines stay 0 whenever `busy_o` is 0.
- R2: A start (`start_i`=1 with `permit_i`=1 while idle) sets `busy_o` and `mux_sel_o` to 1 in the next cycle. Both lines are then held low for HOLD_MS milliseconds.
- R3: During the pattern phase, `scl_o` is high for the first SCL_PERIOD/2 ticks of each SCL_PERIOD-tick period and low for the rest. The first period begins at the first cycle of the pattern.
- R4: During the pattern phase, `sda_o` is low for the first SDA_PERIOD/2 ticks of each SDA_PERIOD-tick period and high for the rest. Its counter restarts together with the SCL counter, so an SDA rise never coincides with an SCL edge.
- R5: The pattern phase lasts PATTERN_MS milliseconds, where one millisecond is TICKS_PER_MS ticks.
- R6: After the pattern phase, both lines are held low for SETTLE_MS milliseconds while `busy_o` and `mux_sel_o` stay 1.
- R7: In the cycle after the settle phase ends, `mux_sel_o` and `busy_o` are 0 and `done_o` is 1. `done_o` is 1 for exactly that one cycle.
- R8: A start request while `permit_i`=0 and idle is refused. `busy_o` stays 0 and `denied_o` is 1 for exactly the next cycle.
- R9: Any start request while `busy_o`=1 is ignored, with or without permit. The timing of the running sequence is unchanged and `denied_o` stays 0.
- R10: One tick is PRESCALE+1 system clock cycles, where PRESCALE is the system clock in MHz minus 1. Hence a millisecond is TICKS_PER_MS*(PRESCALE+1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle sequence request |
| permit_i | input | 1 | Start is allowed when 1 |
| scl_o | output | 1 | Clock-line drive level |
| sda_o | output | 1 | Data-line drive level |
| mux_sel_o | output | 1 | 1: pins owned by this block, 0: pins owned by I2C controller |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| denied_o | output | 1 | One-cycle pulse when a start is refused |

## Verification
Two situations are hard to reach from the ports.

The first is the exact boundary between phases. There, the prescaler wrap, the microsecond wrap and the millisecond match all fall on the same edge. The bench shortens a millisecond to 20 ticks and a tick to two cycles. It then compares every cycle of a whole sequence against a model computed from the requirements, and spot-checks the cycles on either side of each boundary.

The second is a start request that lands on the last busy cycle or arrives without permit mid-sequence. These are injected at chosen cycles of a second run, which must end on the same cycle as the first.

// File: rtl/dfu_entry_pkg.sv
package dfu_entry_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_HOLD    = 2'd1,
    PH_PATTERN = 2'd2,
    PH_SETTLE  = 2'd3
  } phase_e;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dfu_tick_gen.sv
module dfu_tick_gen #(
  parameter int PRESCALE = 49
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  import dfu_entry_pkg::*;

  localparam int PRE_W = cnt_w(PRESCALE + 1);
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESCALE);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             wrap;

  assign wrap = (pre_q == PRE_MAX);
  assign tick = run && wrap;

  always_comb begin
    pre_d = pre_q;
    if (clr)
      pre_d = '0;
    else if (run)
      pre_d = wrap ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else
      pre_q <= pre_d;
  end

endmodule

// File: rtl/dfu_phase_timer.sv
module dfu_phase_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int MS_W         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic [MS_W-1:0] len_ms,
  output logic            phase_end
);
  import dfu_entry_pkg::*;

  localparam int US_W = cnt_w(TICKS_PER_MS);
  localparam logic [US_W-1:0] US_MAX = US_W'(TICKS_PER_MS - 1);

  logic [US_W-1:0] us_q, us_d;
  logic [MS_W-1:0] ms_q, ms_d;
  logic            us_wrap;

  assign us_wrap   = (us_q == US_MAX);
  assign phase_end = tick && us_wrap && (ms_q == len_ms - MS_W'(1));

  always_comb begin
    us_d = us_q;
    ms_d = ms_q;
    if (clr) begin
      us_d = '0;
      ms_d = '0;
    end else if (tick) begin
      if (us_wrap) begin
        us_d = '0;
        ms_d = ms_q + MS_W'(1);
      end else begin
        us_d = us_q + US_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= '0;
      ms_q <= '0;
    end else begin
      us_q <= us_d;
      ms_q <= ms_d;
    end
  end

endmodule

// File: rtl/dfu_wave_gen.sv
module dfu_wave_gen #(
  parameter int SCL_PERIOD = 10,
  parameter int SDA_PERIOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic scl,
  output logic sda
);
  import dfu_entry_pkg::*;

  localparam int SCL_W = cnt_w(SCL_PERIOD);
  localparam int SDA_W = cnt_w(SDA_PERIOD);
  localparam logic [SCL_W-1:0] SCL_MAX  = SCL_W'(SCL_PERIOD - 1);
  localparam logic [SCL_W-1:0] SCL_HIGH = SCL_W'(SCL_PERIOD / 2);
  localparam logic [SDA_W-1:0] SDA_MAX  = SDA_W'(SDA_PERIOD - 1);
  localparam logic [SDA_W-1:0] SDA_LOW  = SDA_W'(SDA_PERIOD / 2);

  logic [SCL_W-1:0] scl_q, scl_d;
  logic [SDA_W-1:0] sda_q, sda_d;
  logic             adv;

  assign adv = run && tick;

  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    if (clr) begin
      scl_d = '0;
      sda_d = '0;
    end else if (adv) begin
      scl_d = (scl_q == SCL_MAX) ? '0 : scl_q + SCL_W'(1);
      sda_d = (sda_q == SDA_MAX) ? '0 : sda_q + SDA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '0;
      sda_q <= '0;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  // SCL: high first half. SDA: inverted, low first, so it rises mid-SCL.
  assign scl = run && (scl_q < SCL_HIGH);
  assign sda = run && (sda_q >= SDA_LOW);

endmodule

// File: rtl/dfu_seq_ctrl.sv
module dfu_seq_ctrl #(
  parameter int HOLD_MS    = 5,
  parameter int PATTERN_MS = 50,
  parameter int SETTLE_MS  = 10,
  parameter int MS_W       = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    permit,
  input  logic                    phase_end,
  output dfu_entry_pkg::phase_e   phase,
  output logic [MS_W-1:0]         len_ms,
  output logic                    accept,
  output logic                    wave_clr,
  output logic                    done,
  output logic                    denied
);
  import dfu_entry_pkg::*;

  localparam logic [MS_W-1:0] LEN_HOLD    = MS_W'(HOLD_MS);
  localparam logic [MS_W-1:0] LEN_PATTERN = MS_W'(PATTERN_MS);
  localparam logic [MS_W-1:0] LEN_SETTLE  = MS_W'(SETTLE_MS);

  phase_e ph_q, ph_d;
  logic   done_q, done_d;
  logic   den_q, den_d;
  logic   idle;

  assign idle   = (ph_q == PH_IDLE);
  assign accept = idle && start && permit;

  always_comb begin
    ph_d     = ph_q;
    done_d   = 1'b0;
    den_d    = idle && start && !permit;
    wave_clr = 1'b0;
    unique case (ph_q)
      PH_IDLE:    if (accept) ph_d = PH_HOLD;
      PH_HOLD:    if (phase_end) begin
                    ph_d     = PH_PATTERN;
                    wave_clr = 1'b1;
                  end
      PH_PATTERN: if (phase_end) ph_d = PH_SETTLE;
      PH_SETTLE:  if (phase_end) begin
                    ph_d   = PH_IDLE;
                    done_d = 1'b1;
                  end
      default:    ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_HOLD:    len_ms = LEN_HOLD;
      PH_PATTERN: len_ms = LEN_PATTERN;
      PH_SETTLE:  len_ms = LEN_SETTLE;
      default:    len_ms = LEN_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
      den_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      den_q  <= den_d;
    end
  end

  assign phase  = ph_q;
  assign done   = done_q;
  assign denied = den_q;

endmodule

// File: rtl/dfu_entry_gen.sv
module dfu_entry_gen #(
  parameter int PRESCALE     = 49,
  parameter int TICKS_PER_MS = 1000,
  parameter int HOLD_MS      = 5,
  parameter int PATTERN_MS   = 50,
  parameter int SETTLE_MS    = 10,
  parameter int SCL_PERIOD   = 10,
  parameter int SDA_PERIOD   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic permit_i,
  output logic scl_o,
  output logic sda_o,
  output logic mux_sel_o,
  output logic busy_o,
  output logic done_o,
  output logic denied_o
);
  import dfu_entry_pkg::*;

  localparam int MAX_MS = (HOLD_MS > PATTERN_MS)
                        ? ((HOLD_MS > SETTLE_MS) ? HOLD_MS : SETTLE_MS)
                        : ((PATTERN_MS > SETTLE_MS) ? PATTERN_MS : SETTLE_MS);
  localparam int MS_W = cnt_w(MAX_MS + 1);

  phase_e          phase;
  logic [MS_W-1:0] len_ms;
  logic            accept, wave_clr, phase_end, tick, busy, in_pattern;

  assign busy       = (phase != PH_IDLE);
  assign in_pattern = (phase == PH_PATTERN);

  dfu_seq_ctrl #(
    .HOLD_MS(HOLD_MS), .PATTERN_MS(PATTERN_MS),
    .SETTLE_MS(SETTLE_MS), .MS_W(MS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .permit(permit_i),
    .phase_end(phase_end), .phase(phase), .len_ms(len_ms),
    .accept(accept), .wave_clr(wave_clr), .done(done_o), .denied(denied_o)
  );

  dfu_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(busy), .tick(tick)
  );

  dfu_phase_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(accept || phase_end), .tick(tick),
    .len_ms(len_ms), .phase_end(phase_end)
  );

  dfu_wave_gen #(.SCL_PERIOD(SCL_PERIOD), .SDA_PERIOD(SDA_PERIOD)) u_wave (
    .clk(clk), .rst_n(rst_n), .clr(wave_clr), .run(in_pattern),
    .tick(tick), .scl(scl_o), .sda(sda_o)
  );

  assign busy_o    = busy;
  assign mux_sel_o = busy;

endmodule

// File: rtl/dfu_entry_chk.sv
module dfu_entry_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic permit_i,
  input logic scl_o,
  input logic sda_o,
  input logic mux_sel_o,
  input logic busy_o,
  input logic done_o,
  input logic denied_o
);

  assert_lines_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_o && !sda_o));

  assert_start_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && permit_i && !busy_o) |=> (busy_o && mux_sel_o));

  assert_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!scl_o && !sda_o && mux_sel_o));

  assert_sda_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_o) |-> $stable(scl_o));

  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !mux_sel_o && $past(busy_o)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_denied_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    denied_o |-> (!busy_o && $past(start_i && !permit_i && !busy_o)));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ((busy_o || done_o) && !denied_o));

endmodule

bind dfu_entry_gen dfu_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .permit_i(permit_i),
  .scl_o(scl_o), .sda_o(sda_o), .mux_sel_o(mux_sel_o), .busy_o(busy_o),
  .done_o(done_o), .denied_o(denied_o)
);

// File: tb/sim_dfu_entry_gen.sv
`timescale 1ns/1ps
module sim_dfu_entry_gen;

  // Shortened timing: tick = 2 cycles, 1 ms = 20 ticks.
  localparam int PRE = 1;
  localparam int TPM = 20;
  localparam int CPT = PRE + 1;
  localparam int HOLD_END = 5 * TPM * CPT;              // 200
  localparam int PAT_END  = HOLD_END + 50 * TPM * CPT;  // 2200
  localparam int SET_END  = PAT_END + 10 * TPM * CPT;   // 2600

  logic clk, rst_n, start_i, permit_i;
  logic scl_o, sda_o, mux_sel_o, busy_o, done_o, denied_o;
  int   errors, checks;

  dfu_entry_gen #(.PRESCALE(PRE), .TICKS_PER_MS(TPM)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .permit_i(permit_i),
    .scl_o(scl_o), .sda_o(sda_o), .mux_sel_o(mux_sel_o), .busy_o(busy_o),
    .done_o(done_o), .denied_o(denied_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {cycle[15:0], req[3:0], scl, sda, busy, done}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {16'd0,    4'd2,  4'b0010},
    {16'd199,  4'd10, 4'b0010},
    {16'd200,  4'd3,  4'b1010},
    {16'd203,  4'd4,  4'b1010},
    {16'd204,  4'd4,  4'b1110},
    {16'd209,  4'd3,  4'b1110},
    {16'd210,  4'd3,  4'b0010},
    {16'd214,  4'd4,  4'b0110},
    {16'd2199, 4'd5,  4'b0110},
    {16'd2200, 4'd6,  4'b0010},
    {16'd2599, 4'd6,  4'b0010},
    {16'd2600, 4'd7,  4'b0001},
    {16'd2601, 4'd7,  4'b0000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected {scl, sda, busy, done} at cycle c after acceptance.
  function automatic logic [3:0] model(input int c);
    int t;
    logic s, d;
    s = 1'b0; d = 1'b0;
    if (c >= HOLD_END && c < PAT_END) begin
      t = (c - HOLD_END) / CPT;
      s = (t % 10) < 5;
      d = (t % 5) >= 2;
    end
    return {s, d, (c < SET_END), (c == SET_END)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  // Run one full sequence; second run injects stray starts (R9).
  task automatic run_seq(input bit inject);
    int bad_hold, bad_scl, bad_sda, bad_set, bad_end, scl_rise, sda_rise;
    logic ps, pd;
    bad_hold = 0; bad_scl = 0; bad_sda = 0; bad_set = 0; bad_end = 0;
    scl_rise = 0; sda_rise = 0; ps = 0; pd = 0;
    start_i = 1'b1; permit_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c <= SET_END + 5; c++) begin
      logic [3:0] e;
      e = model(c);
      if (!inject) begin
        for (int i = 0; i < NV; i++)
          if (int'(VEC[i][23:8]) == c)
            check($sformatf("R%0d table cycle %0d", VEC[i][7:4], c),
                  {3'b0, scl_o, sda_o, busy_o, done_o, mux_sel_o},
                  {3'b0, VEC[i][3:0], VEC[i][1]});
      end
      if (c < HOLD_END && (scl_o || sda_o || !mux_sel_o)) bad_hold++;
      if (scl_o !== e[3]) bad_scl++;
      if (sda_o !== e[2]) bad_sda++;
      if (c >= PAT_END && c < SET_END && (scl_o || sda_o || !busy_o || !mux_sel_o)) bad_set++;
      if (busy_o !== e[1] || done_o !== e[0] || mux_sel_o !== e[1] || denied_o) bad_end++;
      if (scl_o && !ps) scl_rise++;
      if (sda_o && !pd) sda_rise++;
      ps = scl_o; pd = sda_o;
      if (inject) begin
        start_i  = (c == 299) || (c == 499) || (c == SET_END - 2);
        permit_i = !(c == 499);
      end
      @(negedge clk);
    end
    start_i = 1'b0; permit_i = 1'b1;
    if (!inject) begin
      check("R2 hold low", 8'(bad_hold), 8'd0);
      check("R3 scl wave", 8'(bad_scl), 8'd0);
      check("R4 sda wave", 8'(bad_sda), 8'd0);
      check("R5 scl rises in pattern", 8'(scl_rise), 8'd100);
      check("R5 sda rises in pattern", 8'(sda_rise), 8'd200);
      check("R6 settle low", 8'(bad_set), 8'd0);
      check("R7 end and done", 8'(bad_end), 8'd0);
    end else begin
      check("R9 start while busy: lines", 8'(bad_scl + bad_sda), 8'd0);
      check("R9 start while busy: timing", 8'(bad_end), 8'd0);
    end
  endtask

  initial begin : main
    errors = 0; checks = 0;
    rst_n = 1'b0; start_i = 1'b0; permit_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state",
          {2'b0, scl_o, sda_o, mux_sel_o, busy_o, done_o, denied_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release",
          {2'b0, scl_o, sda_o, mux_sel_o, busy_o, done_o, denied_o}, 8'd0);

    // R8: refused start
    permit_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; permit_i = 1'b1;
    check("R8 denied raised, no start", {5'b0, denied_o, busy_o, mux_sel_o}, 8'b100);
    @(negedge clk);
    check("R8 denied one cycle", {6'b0, denied_o, busy_o}, 8'b0);
    repeat (5) @(negedge clk);
    check("R8 still idle", {6'b0, busy_o, mux_sel_o}, 8'b0);

    // Full sequence with table and per-cycle model (R2-R7, R10)
    run_seq(1'b0);
    repeat (3) @(negedge clk);
    check("R1 idle after sequence",
          {2'b0, scl_o, sda_o, mux_sel_o, busy_o, done_o, denied_o}, 8'd0);

    // R9: stray starts mid-run and on the last busy cycle
    run_seq(1'b1);
    check("R9 no restart after end", {6'b0, busy_o, done_o}, 8'b0);

    finish_run();
  end

endmodule